// File: doc/BRIEF.md
# Flash Byte Programming Controller

This block models the parallel programming port of a small on-chip code flash. The array is held in registers inside the block. A 3-bit mode selector, an address bus, an 8-bit data-in bus and an active-low programming strobe `pulseN` drive it. It returns a read byte and a `ready` flag. One falling edge of the strobe starts a byte write or a lock-bit program, and internal counters time the operation. The write cycle count is a parameter so that a bench can shorten it. Holding the strobe low in erase mode for a set number of clocks starts a chip erase. The erase walks the whole array to the blank value and clears every lock bit.

A host can poll for completion in two ways. It can watch `ready`, or it can read back the byte that is being written. While that write is in flight, the read returns the result byte with its top bit inverted, so the true value shows up on the bus when the cycle ends. Programming can only clear bits. A byte that has been written once can only be raised again by a chip erase. Three fixed identification bytes can be read in signature mode. Verify reads are blanked while either of the first two lock bits is programmed.

Top module: `flash_prog_top`

## Requirements
- R1: After reset `ready` is 1 and no operation is in progress.
- R2: With mode 3'b001 (write), a falling edge of `pulseN` while `ready` is 1 captures `addr` and `dataIn`. `ready` is 0 from the next cycle for exactly WRITE_CYCLES cycles and then returns to 1.
- R3: A completed write stores the bitwise AND of the old byte and `dataIn`. Bits can only be cleared, never set.
- R4: With mode 3'b000 (verify), reading the address of the write in flight returns the byte being stored with bit 7 inverted. Once `ready` is back to 1 the true byte is returned.
- R5: A falling edge of `pulseN` while `ready` is 0 is ignored. No further write or lock operation is started.
- R6: With mode 3'b010 (erase), holding `pulseN` low for ERASE_HOLD consecutive cycles starts an erase. `ready` is 0 while every byte is set to FFh and all lock bits are cleared. A shorter low pulse changes nothing.
- R7: With mode 3'b110 (signature), address 030h reads 1Eh, 031h reads 51h, and 032h reads FFh when HIGH_VOLT is 1 or 05h when it is 0. Any other address reads 00h.
- R8: Modes 3'b011, 3'b100 and 3'b101 program lock bits 1, 2 and 3 with a self-timed cycle like a write. While lock bit 1 or 2 is programmed, verify reads return FFh. Lock bit 3 alone leaves verify reads unchanged.
- R9: When no lock blocks it and no write is in flight to that address, a verify read returns the stored byte at `addr`. Mode 3'b111 reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseN | input | 1 | Active-low programming strobe |
| mode | input | 3 | Operation select |
| addr | input | ADDR_W (12) | Byte address |
| dataIn | input | 8 | Byte to program |
| rdData | output | 8 | Verify, polling or signature read byte |
| ready | output | 1 | 1 when idle, 0 while a write, lock program or erase runs |

## Verification
The checker runs every cycle and covers four things. `ready` drops right after an accepted strobe. No busy period outlasts the longer of the write and erase durations. The signature bytes are fixed. An idle verify read with stable inputs holds still. The bench scenarios cover everything that depends on history: the AND-only programming, the inverted bit 7 during polling, a strobe ignored while busy, an erase cut short, and lock bits that blank reads until an erase clears them.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    MODE_VERIFY    = 3'd0,
    MODE_WRITE     = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_LOCK1     = 3'd3,
    MODE_LOCK2     = 3'd4,
    MODE_LOCK3     = 3'd5,
    MODE_SIGNATURE = 3'd6,
    MODE_NONE      = 3'd7
  } flashMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch address, data, target
    logic commit;      // end of self-timed program cycle
    logic clearLocks;  // erase begins
    logic eraseWr;     // write blank byte at sweep address
  } ctrlStrobe_t;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int WRITE_CYCLES = 75000,
  parameter int ERASE_HOLD   = 500000,
  parameter int MEM_DEPTH    = 4096,
  localparam int ADDR_W = $clog2(MEM_DEPTH),
  localparam int WCNT_W = $clog2(WRITE_CYCLES + 1),
  localparam int HCNT_W = $clog2(ERASE_HOLD + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseN,
  input  logic [2:0]        mode,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic              writeBusy,
  output logic              eraseBusy
);

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_ERASE} state_e;

  state_e            state;
  logic              prevPulse;
  logic              armed;
  logic [WCNT_W-1:0] waitCnt;
  logic [HCNT_W-1:0] holdCnt;

  logic fallEdge, isProgMode, startProg, holdDone, sweepLast;

  assign fallEdge   = prevPulse & ~pulseN;
  assign isProgMode = (mode == MODE_WRITE) || (mode == MODE_LOCK1) ||
                      (mode == MODE_LOCK2) || (mode == MODE_LOCK3);
  assign startProg  = (state == ST_IDLE) && fallEdge && isProgMode;
  assign holdDone   = (state == ST_IDLE) && (mode == MODE_ERASE) && !pulseN &&
                      armed && (holdCnt == HCNT_W'(ERASE_HOLD - 1));
  assign sweepLast  = (sweepAddr == ADDR_W'(MEM_DEPTH - 1));

  always_comb begin
    strobe            = '0;
    strobe.capture    = startProg;
    strobe.commit     = (state == ST_WRITE) && (waitCnt == '0);
    strobe.clearLocks = holdDone;
    strobe.eraseWr    = (state == ST_ERASE);
  end

  assign writeBusy = (state == ST_WRITE);
  assign eraseBusy = (state == ST_ERASE);

  always_ff @(posedge clk) begin
    if (!rstN) prevPulse <= 1'b1;
    else       prevPulse <= pulseN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        armed <= 1'b1;
    else if (pulseN)  armed <= 1'b1;
    else if (holdDone) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      holdCnt <= '0;
    else if (pulseN || mode != MODE_ERASE || state != ST_IDLE || !armed || holdDone)
      holdCnt <= '0;
    else
      holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      sweepAddr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startProg) begin
            state   <= ST_WRITE;
            waitCnt <= WCNT_W'(WRITE_CYCLES - 1);
          end else if (holdDone) begin
            state     <= ST_ERASE;
            sweepAddr <= '0;
          end
        end
        ST_WRITE: begin
          if (waitCnt == '0) state <= ST_IDLE;
          else               waitCnt <= waitCnt - 1'b1;
        end
        ST_ERASE: begin
          if (sweepLast) state <= ST_IDLE;
          else           sweepAddr <= sweepAddr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_datapath.sv
module flash_prog_datapath
  import flash_prog_pkg::*;
#(
  parameter int MEM_DEPTH = 4096,
  parameter bit HIGH_VOLT = 1'b1,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int LOCK_N   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  logic              writeBusy,
  input  logic              eraseBusy,
  output logic [7:0]        rdData
);

  logic [7:0]        mem [MEM_DEPTH];
  logic [LOCK_N-1:0] lockBits;
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        lastData;
  logic              lastIsLock;
  logic [1:0]        lastLockIdx;

  // capture the target of a program cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastAddr    <= '0;
      lastData    <= BLANK_BYTE;
      lastIsLock  <= 1'b0;
      lastLockIdx <= '0;
    end else if (strobe.capture) begin
      lastAddr    <= addr;
      lastData    <= mem[addr] & dataIn;
      lastIsLock  <= (mode != MODE_WRITE);
      lastLockIdx <= 2'(mode - 3'(MODE_LOCK1));
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.eraseWr)
      mem[sweepAddr] <= BLANK_BYTE;
    else if (strobe.commit && !lastIsLock)
      mem[lastAddr] <= lastData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      lockBits <= '0;
    else if (strobe.clearLocks)
      lockBits <= '0;
    else if (strobe.commit && lastIsLock)
      lockBits[lastLockIdx] <= 1'b1;
  end

  logic [7:0] sigByte;
  always_comb begin
    case (addr)
      ADDR_W'(12'h030): sigByte = 8'h1E;
      ADDR_W'(12'h031): sigByte = 8'h51;
      ADDR_W'(12'h032): sigByte = HIGH_VOLT ? 8'hFF : 8'h05;
      default:          sigByte = 8'h00;
    endcase
  end

  logic pollHit, readBlocked;
  assign pollHit     = writeBusy && !lastIsLock && (addr == lastAddr);
  assign readBlocked = lockBits[0] | lockBits[1] | eraseBusy;

  always_comb begin
    case (mode)
      MODE_VERIFY: begin
        if (pollHit)          rdData = {~lastData[7], lastData[6:0]};
        else if (readBlocked) rdData = BLANK_BYTE;
        else                  rdData = mem[addr];
      end
      MODE_SIGNATURE: rdData = sigByte;
      default:        rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_prog_top.sv
module flash_prog_top
  import flash_prog_pkg::*;
#(
  parameter int WRITE_CYCLES = 75000,
  parameter int ERASE_HOLD   = 500000,
  parameter int MEM_DEPTH    = 4096,
  parameter bit HIGH_VOLT    = 1'b1,
  localparam int ADDR_W      = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseN,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        rdData,
  output logic              ready
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] sweepAddr;
  logic              writeBusy, eraseBusy;

  flash_prog_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES), .ERASE_HOLD(ERASE_HOLD), .MEM_DEPTH(MEM_DEPTH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pulseN(pulseN), .mode(mode),
    .strobe(strobe), .sweepAddr(sweepAddr),
    .writeBusy(writeBusy), .eraseBusy(eraseBusy)
  );

  flash_prog_datapath #(
    .MEM_DEPTH(MEM_DEPTH), .HIGH_VOLT(HIGH_VOLT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .addr(addr), .dataIn(dataIn),
    .strobe(strobe), .sweepAddr(sweepAddr),
    .writeBusy(writeBusy), .eraseBusy(eraseBusy), .rdData(rdData)
  );

  assign ready = ~(writeBusy | eraseBusy);

endmodule

// File: rtl/flash_prog_checker.sv
module flash_prog_checker #(
  parameter int WRITE_CYCLES = 75000,
  parameter int MEM_DEPTH    = 4096,
  parameter bit HIGH_VOLT    = 1'b1,
  localparam int ADDR_W      = $clog2(MEM_DEPTH),
  localparam int LIMIT       = (WRITE_CYCLES > MEM_DEPTH) ? WRITE_CYCLES : MEM_DEPTH,
  localparam int RUN_W       = $clog2(LIMIT + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pulseN,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dataIn,
  input logic [7:0]        rdData,
  input logic              ready
);

  logic [RUN_W-1:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rstN || ready)        busyRun <= '0;
    else if (busyRun != '1)    busyRun <= busyRun + 1'b1;
  end

  AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(pulseN) && !pulseN && mode == 3'd1) |=> !ready) else $error("strobe not accepted"); // R2

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(LIMIT)) else $error("busy too long"); // R6

  AST_SIG_ID: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd6 && addr == ADDR_W'(12'h031)) |-> rdData == 8'h51) else $error("signature"); // R7

  AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready) && mode == 3'd0 && $past(mode) == 3'd0 && $stable(addr))
      |-> $stable(rdData)) else $error("read drift"); // R9

endmodule

bind flash_prog_top flash_prog_checker #(
  .WRITE_CYCLES(WRITE_CYCLES), .MEM_DEPTH(MEM_DEPTH), .HIGH_VOLT(HIGH_VOLT)
) u_chk (
  .clk(clk), .rstN(rstN), .pulseN(pulseN), .mode(mode), .addr(addr),
  .dataIn(dataIn), .rdData(rdData), .ready(ready)
);

// File: tb/tb_flash_prog_top.sv
`timescale 1ns/1ps
module tb_flash_prog_top;
  localparam int WC    = 20;
  localparam int EH    = 30;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pulseN = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic [11:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  rdData;
  logic        ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_prog_top #(.WRITE_CYCLES(WC), .ERASE_HOLD(EH), .MEM_DEPTH(DEPTH), .HIGH_VOLT(1'b1))
    dut (.clk(clk), .rstN(rstN), .pulseN(pulseN), .mode(mode), .addr(addr),
         .dataIn(dataIn), .rdData(rdData), .ready(ready));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [2:0] m, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); mode = m; addr = a; dataIn = d; pulseN = 1'b0;
    @(negedge clk); pulseN = 1'b1;
  endtask

  task automatic waitReady();
    for (int i = 0; i < DEPTH + 100 && !ready; i++) @(negedge clk);
  endtask

  task automatic readAt(input logic [2:0] m, input logic [11:0] a, output logic [7:0] v);
    @(negedge clk); mode = m; addr = a; #1; v = rdData;
  endtask

  task automatic eraseChip(input int holdCycles);
    @(negedge clk); mode = 3'd2; pulseN = 1'b0;
    repeat (holdCycles) @(negedge clk);
    pulseN = 1'b1;
    @(negedge clk);
    waitReady();
  endtask

  task automatic testReset();
    check("R1 ready after reset", {7'd0, ready}, 8'h01);
  endtask

  task automatic testWriteTiming();
    int lowCnt = 0;
    logic [7:0] v;
    eraseChip(EH);
    check("R6 erase done", {7'd0, ready}, 8'h01);
    readAt(3'd0, 12'hABC, v); check("R6 erased byte FF", v, 8'hFF);
    strobe(3'd1, 12'h010, 8'hA5);
    // now one negedge after accepting edge
    while (!ready && lowCnt < WC + 10) begin lowCnt++; @(negedge clk); end
    check("R2 busy length", 8'(lowCnt), 8'(WC));
    readAt(3'd0, 12'h010, v); check("R9 read written byte", v, 8'hA5);
  endtask

  task automatic testPolling();
    logic [7:0] v;
    strobe(3'd1, 12'h010, 8'h0F);
    check("R2 ready low", {7'd0, ready}, 8'h00);
    readAt(3'd0, 12'h010, v); check("R4 polling bit7 inverted", v, 8'h85);
    readAt(3'd0, 12'h011, v); check("R9 other address during write", v, 8'hFF);
    waitReady();
    readAt(3'd0, 12'h010, v); check("R3 AND of old and new", v, 8'h05);
    check("R4 true data after write", v, 8'h05);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] v;
    strobe(3'd1, 12'h005, 8'h3C);
    repeat (3) @(negedge clk);
    strobe(3'd1, 12'h006, 8'h00);
    waitReady();
    repeat (2) @(negedge clk);
    check("R5 no second cycle", {7'd0, ready}, 8'h01);
    readAt(3'd0, 12'h006, v); check("R5 ignored strobe left byte", v, 8'hFF);
    readAt(3'd0, 12'h005, v); check("R2 first write stored", v, 8'h3C);
  endtask

  task automatic testSignature();
    logic [7:0] v;
    readAt(3'd6, 12'h030, v); check("R7 sig 030", v, 8'h1E);
    readAt(3'd6, 12'h031, v); check("R7 sig 031", v, 8'h51);
    readAt(3'd6, 12'h032, v); check("R7 sig 032", v, 8'hFF);
    readAt(3'd6, 12'h033, v); check("R7 sig other", v, 8'h00);
    readAt(3'd7, 12'h005, v); check("R9 unused mode", v, 8'h00);
  endtask

  task automatic testShortErase();
    logic [7:0] v;
    eraseChip(EH - 1);
    readAt(3'd0, 12'h005, v); check("R6 short pulse no erase", v, 8'h3C);
  endtask

  task automatic testLocks();
    logic [7:0] v;
    strobe(3'd5, 12'h000, 8'h00);
    check("R8 lock program busy", {7'd0, ready}, 8'h00);
    waitReady();
    readAt(3'd0, 12'h005, v); check("R8 lock3 no read effect", v, 8'h3C);
    strobe(3'd3, 12'h000, 8'h00);
    waitReady();
    readAt(3'd0, 12'h005, v); check("R8 lock1 blanks read", v, 8'hFF);
    readAt(3'd6, 12'h030, v); check("R7 sig with lock", v, 8'h1E);
    eraseChip(EH);
    strobe(3'd1, 12'h020, 8'h5A);
    waitReady();
    readAt(3'd0, 12'h020, v); check("R6 locks cleared by erase", v, 8'h5A);
    readAt(3'd0, 12'h005, v); check("R6 erased old byte", v, 8'hFF);
    strobe(3'd4, 12'h000, 8'h00);
    waitReady();
    readAt(3'd0, 12'h020, v); check("R8 lock2 blanks read", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteTiming();
    testPolling();
    testBusyIgnore();
    testSignature();
    testShortErase();
    testLocks();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule